// File: doc/BRIEF.md
# Four-Lane Deskew Aligner

This block takes four lanes of already-decoded octets, each with a control flag and a per-lane code-group-lock indication, all in one clock domain. The lanes may arrive skewed against each other by a few columns. The block stores each lane in a short circular buffer. It searches for the align character on every lane and gives each lane its own read delay, so that the align characters leave in the same output column. It then presents one 32-bit word with four control bits.

The search starts only while all four lanes report lock. If the align characters do not all arrive within a bounded window, the block raises a one-cycle error pulse, counts the event in a saturating counter and starts a new search. Once aligned, every column that carries the align character on one lane must carry it on all lanes; a column that breaks this rule ends the aligned state. While aligned, the block replaces the align, sync and skip characters with the idle character. While not aligned, it sends idle columns only.

Top module: `quad_lane_aligner`

## Requirements
- R1: After reset the output columns are idle (each lane octet 0x07, every control bit 1), `deskew_ok_o` is 0, `align_err_o` is 0 and `err_count_o` is 0.
- R2: Lane n travels in bits [8n+7:8n] of the data ports and in bit n of the control ports. The align character is 0x7C with control 1, sync is 0xBC with control 1, skip is 0x1C with control 1 and idle is 0x07 with control 1.
- R3: The search for alignment runs only in cycles where all `lane_sync_i` bits are 1. A cycle with any bit at 0 clears `deskew_ok_o` on the next edge and discards any search in progress.
- R4: Let the last lane present its align character in cycle t, with a spread below MAX_SKEW cycles since the first one. Then `deskew_ok_o` rises after the edge of cycle t. Each lane is delayed by its own lead, so an octet presented in cycle c appears on the output after the edge of cycle c+1+delay.
- R5: Let the first align character of a search arrive in cycle t0. If some lane has not presented one in cycles t0 to t0+MAX_SKEW-1, `align_err_o` pulses for one cycle after the edge of cycle t0+MAX_SKEW. An align character in that cycle is ignored, and the search restarts from the next cycle.
- R6: `err_count_o` counts `align_err_o` pulses and stays at its all-ones value once it reaches it. `err_clr_i` clears it on the next edge, and a clear wins over a count in the same cycle.
- R7: A column produced while `deskew_ok_o` is 0, or while any lane lacks lock, is an idle column.
- R8: While aligned, align, sync and skip characters leave as idle. Every other octet, including other control characters such as 0xFB with control 1, leaves unchanged.
- R9: While aligned, a delayed column with the align character on some lanes but not all leaves as an idle column and clears `deskew_ok_o`. A new search starts, and the event is not counted as an alignment error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all lanes |
| rst_n | input | 1 | Synchronous active-low reset |
| lane_data_i | input | 32 | One decoded octet per lane |
| lane_ctrl_i | input | 4 | Control flag per lane |
| lane_sync_i | input | 4 | Code-group lock per lane |
| err_clr_i | input | 1 | Synchronous clear of the error counter |
| out_data_o | output | 32 | Aligned, remapped output word |
| out_ctrl_o | output | 4 | Control bits of the output word |
| deskew_ok_o | output | 1 | Lanes are aligned |
| align_err_o | output | 1 | One-cycle pulse when the window expires |
| err_count_o | output | 16 | Saturating alignment-error count |

## Verification
The bench builds the block with four lanes, an eight-entry buffer and a five-cycle window, but shrinks the error counter to 4 bits. With that width, saturation and the clear that follows it are reached after a few hundred cycles of windows that fail on purpose. Skews of 0/1/2/4 hit the widest spread that still aligns. Skews of 0/5/1/2 miss the window by exactly one cycle. Equal skews check the zero-delay case. A single missing align character on one lane checks the mismatch path, and dropped lock on one lane checks that the search is gated.

// File: rtl/qla_pkg.sv
// Package: shared symbol type, special character codes and helpers
// for the four-lane deskew aligner. Assumes octets arrive already decoded.
package qla_pkg;

    localparam logic [7:0] SYM_ALIGN = 8'h7C;
    localparam logic [7:0] SYM_SYNC  = 8'hBC;
    localparam logic [7:0] SYM_SKIP  = 8'h1C;
    localparam logic [7:0] SYM_IDLE  = 8'h07;

    typedef struct packed {
        logic       ctrl;
        logic [7:0] data;
    } lane_sym_t;

    localparam lane_sym_t IDLE_SYM = '{ctrl: 1'b1, data: SYM_IDLE};

    // True when the symbol is the align character.
    function automatic logic is_align(lane_sym_t s);
        return s.ctrl && (s.data == SYM_ALIGN);
    endfunction

    // Replace align, sync and skip characters with idle.
    function automatic lane_sym_t to_output(lane_sym_t s);
        if (s.ctrl && (s.data == SYM_ALIGN || s.data == SYM_SYNC || s.data == SYM_SKIP))
            return IDLE_SYM;
        return s;
    endfunction

endpackage

// File: rtl/qla_lane_fifo.sv
// Per-lane delay buffer: writes one symbol each cycle into a circular
// store and reads the symbol written rd_delay+1 cycles earlier.
// Assumes DEPTH is a power of two and rd_delay < DEPTH.
module qla_lane_fifo #(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  qla_pkg::lane_sym_t  in_sym,
    input  logic [AW-1:0]       rd_delay,
    output qla_pkg::lane_sym_t  tap_sym
);
    qla_pkg::lane_sym_t mem [DEPTH];
    logic [AW-1:0]      wr_ptr;
    logic [AW-1:0]      rd_ptr;

    // Read address trails the write pointer by one plus the lane delay.
    always_comb rd_ptr = wr_ptr - AW'(1) - rd_delay;

    assign tap_sym = mem[rd_ptr];

    // Store the incoming symbol and advance the write pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
        end else begin
            mem[wr_ptr] <= in_sym;
            wr_ptr      <= wr_ptr + AW'(1);
        end
    end
endmodule

// File: rtl/qla_align_ctrl.sv
// Alignment controller: watches the incoming align characters, times the
// spread across lanes, sets per-lane read delays, holds the aligned flag
// and detects window expiry and post-alignment column mismatches.
// Assumes MAX_SKEW <= 2**AW so every delay fits the buffer.
module qla_align_ctrl #(
    parameter int LANES    = 4,
    parameter int MAX_SKEW = 5,
    parameter int AW       = 3,
    localparam int WIN_W   = $clog2(MAX_SKEW + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LANES-1:0]          lane_sync,
    input  logic [LANES-1:0]          in_align,
    input  logic [LANES-1:0]          tap_align,
    output logic [LANES-1:0][AW-1:0]  rd_delay,
    output logic                      deskew_ok,
    output logic                      mismatch,
    output logic                      err_event,
    output logic                      align_err
);
    logic [LANES-1:0]          seen_q;
    logic [LANES-1:0][AW-1:0]  age_q;
    logic [WIN_W-1:0]          win_q;
    logic                      all_sync;
    logic                      searching;
    logic                      complete;

    // Decode the search conditions for this cycle.
    always_comb begin
        all_sync  = &lane_sync;
        searching = all_sync && !deskew_ok;
        mismatch  = deskew_ok && (|tap_align) && !(&tap_align);
        err_event = searching && (seen_q != '0) && (win_q >= WIN_W'(MAX_SKEW));
        complete  = searching && !err_event && (&(seen_q | in_align))
                    && ((seen_q != '0) || (&in_align));
    end

    // Advance the search: record arrivals, age them and count the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
            win_q  <= '0;
            age_q  <= '0;
        end else if (!searching || err_event || complete) begin
            seen_q <= '0;
            win_q  <= '0;
        end else if ((seen_q != '0) || (|in_align)) begin
            seen_q <= seen_q | in_align;
            win_q  <= win_q + WIN_W'(1);
            for (int l = 0; l < LANES; l++)
                age_q[l] <= seen_q[l] ? age_q[l] + AW'(1) : '0;
        end
    end

    // Hold the aligned flag, latch delays on completion, register the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deskew_ok <= 1'b0;
            align_err <= 1'b0;
            rd_delay  <= '0;
        end else begin
            align_err <= err_event;
            if (!all_sync || mismatch)
                deskew_ok <= 1'b0;
            else if (complete)
                deskew_ok <= 1'b1;
            if (complete)
                for (int l = 0; l < LANES; l++)
                    rd_delay[l] <= seen_q[l] ? age_q[l] + AW'(1) : '0;
        end
    end
endmodule

// File: rtl/qla_err_count.sv
// Saturating event counter with a synchronous clear that takes priority.
module qla_err_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    // Clear, or count up until all ones.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            count <= '0;
        else if (inc && (count != '1))
            count <= count + W'(1);
    end
endmodule

// File: rtl/quad_lane_aligner.sv
// Top of the lane deskew aligner: one delay buffer per lane, a shared
// alignment controller, an error counter and a registered output stage
// that forces idle columns until alignment holds. Lanes share one clock.
module quad_lane_aligner #(
    parameter int LANES      = 4,
    parameter int FIFO_DEPTH = 8,
    parameter int MAX_SKEW   = 5,
    parameter int CNT_W      = 16,
    localparam int AW        = $clog2(FIFO_DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LANES*8-1:0]   lane_data_i,
    input  logic [LANES-1:0]     lane_ctrl_i,
    input  logic [LANES-1:0]     lane_sync_i,
    input  logic                 err_clr_i,
    output logic [LANES*8-1:0]   out_data_o,
    output logic [LANES-1:0]     out_ctrl_o,
    output logic                 deskew_ok_o,
    output logic                 align_err_o,
    output logic [CNT_W-1:0]     err_count_o
);
    import qla_pkg::*;

    lane_sym_t                in_sym  [LANES];
    lane_sym_t                tap_sym [LANES];
    lane_sym_t                out_q   [LANES];
    logic [LANES-1:0]         in_align;
    logic [LANES-1:0]         tap_align;
    logic [LANES-1:0][AW-1:0] rd_delay;
    logic                     mismatch;
    logic                     err_event;
    logic                     force_idle;

    assign force_idle = !deskew_ok_o || !(&lane_sync_i) || mismatch;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign in_sym[g]    = '{ctrl: lane_ctrl_i[g], data: lane_data_i[g*8 +: 8]};
        assign in_align[g]  = is_align(in_sym[g]);
        assign tap_align[g] = is_align(tap_sym[g]);

        qla_lane_fifo #(.DEPTH(FIFO_DEPTH)) fifo_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_sym   (in_sym[g]),
            .rd_delay (rd_delay[g]),
            .tap_sym  (tap_sym[g])
        );

        // Register this lane's output octet, idle unless aligned.
        always_ff @(posedge clk) begin
            if (!rst_n || force_idle)
                out_q[g] <= IDLE_SYM;
            else
                out_q[g] <= to_output(tap_sym[g]);
        end

        assign out_data_o[g*8 +: 8] = out_q[g].data;
        assign out_ctrl_o[g]        = out_q[g].ctrl;
    end

    qla_align_ctrl #(
        .LANES    (LANES),
        .MAX_SKEW (MAX_SKEW),
        .AW       (AW)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lane_sync (lane_sync_i),
        .in_align  (in_align),
        .tap_align (tap_align),
        .rd_delay  (rd_delay),
        .deskew_ok (deskew_ok_o),
        .mismatch  (mismatch),
        .err_event (err_event),
        .align_err (align_err_o)
    );

    qla_err_count #(.W(CNT_W)) cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (err_clr_i),
        .inc   (err_event),
        .count (err_count_o)
    );
endmodule

// File: rtl/qla_checker.sv
// Property checker for the lane aligner, attached by bind below.
module qla_checker #(
    parameter int LANES = 4,
    parameter int CNT_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic [LANES*8-1:0]  out_data_o,
    input logic [LANES-1:0]    out_ctrl_o,
    input logic [LANES-1:0]    lane_sync_i,
    input logic                err_clr_i,
    input logic                deskew_ok_o,
    input logic                align_err_o,
    input logic [CNT_W-1:0]    err_count_o
);
    // R7: a column produced while unaligned is idle.
    assert_idle_unaligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !deskew_ok_o |=> (out_data_o == {LANES{8'h07}} && out_ctrl_o == '1));

    // R3: missing lock drops the aligned flag.
    assert_sync_loss_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(&lane_sync_i) |=> !deskew_ok_o);

    // R5: an error pulse only occurs while not aligned.
    assert_err_unaligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        align_err_o |-> !deskew_ok_o);

    // R6: the clear empties the counter.
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr_i |=> err_count_o == '0);

    // R6: without a clear the counter never decreases or wraps.
    assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr_i |=> err_count_o >= $past(err_count_o));

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        // R8: no align, sync or skip character reaches the output.
        assert_no_special_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !(out_ctrl_o[g] && (out_data_o[g*8 +: 8] == 8'h7C ||
                                out_data_o[g*8 +: 8] == 8'hBC ||
                                out_data_o[g*8 +: 8] == 8'h1C)));
    end
endmodule

bind quad_lane_aligner qla_checker #(.LANES(LANES), .CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .out_data_o  (out_data_o),
    .out_ctrl_o  (out_ctrl_o),
    .lane_sync_i (lane_sync_i),
    .err_clr_i   (err_clr_i),
    .deskew_ok_o (deskew_ok_o),
    .align_err_o (align_err_o),
    .err_count_o (err_count_o)
);

// File: tb/quad_lane_aligner_tb_top.sv
`timescale 1ns/1ps
module quad_lane_aligner_tb_top;
    localparam int LANES = 4;
    localparam int DEPTH = 8;
    localparam int SKEW  = 5;
    localparam int CW    = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n;
    logic [31:0]       lane_data_i;
    logic [3:0]        lane_ctrl_i;
    logic [3:0]        lane_sync_i;
    logic              err_clr_i;
    logic [31:0]       out_data_o;
    logic [3:0]        out_ctrl_o;
    logic              deskew_ok_o;
    logic              align_err_o;
    logic [CW-1:0]     err_count_o;

    quad_lane_aligner #(.LANES(LANES), .FIFO_DEPTH(DEPTH), .MAX_SKEW(SKEW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .lane_data_i(lane_data_i), .lane_ctrl_i(lane_ctrl_i),
        .lane_sync_i(lane_sync_i), .err_clr_i(err_clr_i), .out_data_o(out_data_o),
        .out_ctrl_o(out_ctrl_o), .deskew_ok_o(deskew_ok_o), .align_err_o(align_err_o),
        .err_count_o(err_count_o)
    );

    int total = 0, bad = 0;
    bit done = 0;

    // stimulus state
    int skew [LANES];
    int cyc_d = 0;
    bit kill_arm = 0;
    bit sync_v [LANES];
    bit clr_v = 0;
    int saw_fb = 0, saw_special = 0;

    // reference model state
    int h_d [LANES][DEPTH];
    int h_c [LANES][DEPTH];
    int m_dly [LANES];
    int m_arr [LANES];
    bit m_seen [LANES];
    bit m_ok = 0, m_err = 0;
    int m_first = 0, m_cyc = 0, m_cnt = 0;
    logic [31:0] m_data = 32'h07070707;
    logic [3:0]  m_ctrl = 4'hF;

    task automatic model_step();
        bit all_s, any_a, all_a, mm, any_in, all_in, err_now;
        bit ta [LANES];
        bit ia [LANES];
        if (!rst_n) begin
            m_ok = 0; m_err = 0; m_cnt = 0; m_cyc = 0;
            m_data = 32'h07070707; m_ctrl = 4'hF;
            for (int l = 0; l < LANES; l++) begin
                m_dly[l] = 0; m_seen[l] = 0;
                for (int k = 0; k < DEPTH; k++) begin h_d[l][k] = 0; h_c[l][k] = 0; end
            end
            return;
        end
        all_s = 1; any_a = 0; all_a = 1; any_in = 0; all_in = 1;
        for (int l = 0; l < LANES; l++) begin
            all_s &= lane_sync_i[l];
            ta[l] = (h_c[l][m_dly[l]] == 1) && (h_d[l][m_dly[l]] == 8'h7C);
            ia[l] = lane_ctrl_i[l] && (lane_data_i[l*8 +: 8] == 8'h7C);
            any_a |= ta[l]; all_a &= ta[l];
            any_in |= ia[l]; all_in &= ia[l];
        end
        mm = m_ok && any_a && !all_a;
        for (int l = 0; l < LANES; l++) begin
            int d, c;
            d = h_d[l][m_dly[l]]; c = h_c[l][m_dly[l]];
            if (!m_ok || !all_s || mm || (c == 1 && (d == 8'h7C || d == 8'hBC || d == 8'h1C))) begin
                d = 8'h07; c = 1;
            end
            m_data[l*8 +: 8] = d[7:0];
            m_ctrl[l] = c[0];
        end
        err_now = 0;
        if (!all_s) begin
            m_ok = 0;
            for (int l = 0; l < LANES; l++) m_seen[l] = 0;
        end else if (m_ok) begin
            if (mm) begin
                m_ok = 0;
                for (int l = 0; l < LANES; l++) m_seen[l] = 0;
            end
        end else begin
            bit none_seen, all_now;
            none_seen = 1; all_now = 1;
            for (int l = 0; l < LANES; l++) begin
                if (m_seen[l]) none_seen = 0;
                if (!(m_seen[l] || ia[l])) all_now = 0;
            end
            if (none_seen) begin
                if (all_in) begin
                    m_ok = 1;
                    for (int l = 0; l < LANES; l++) m_dly[l] = 0;
                end else if (any_in) begin
                    m_first = m_cyc;
                    for (int l = 0; l < LANES; l++)
                        if (ia[l]) begin m_seen[l] = 1; m_arr[l] = m_cyc; end
                end
            end else if (m_cyc - m_first >= SKEW) begin
                err_now = 1;
                for (int l = 0; l < LANES; l++) m_seen[l] = 0;
            end else begin
                for (int l = 0; l < LANES; l++)
                    if (ia[l] && !m_seen[l]) begin m_seen[l] = 1; m_arr[l] = m_cyc; end
                if (all_now) begin
                    m_ok = 1;
                    for (int l = 0; l < LANES; l++) begin
                        m_dly[l] = m_cyc - m_arr[l];
                        m_seen[l] = 0;
                    end
                end
            end
        end
        m_err = err_now;
        if (err_clr_i) m_cnt = 0;
        else if (err_now && m_cnt < (1 << CW) - 1) m_cnt++;
        for (int l = 0; l < LANES; l++) begin
            for (int k = DEPTH - 1; k > 0; k--) begin
                h_d[l][k] = h_d[l][k-1]; h_c[l][k] = h_c[l][k-1];
            end
            h_d[l][0] = lane_data_i[l*8 +: 8];
            h_c[l][0] = lane_ctrl_i[l];
        end
        m_cyc++;
    endtask

    always @(posedge clk) model_step();

    task automatic drive();
        for (int l = 0; l < LANES; l++) begin
            int p, ph;
            logic [7:0] d;
            logic c;
            p = cyc_d - skew[l];
            ph = ((p % 16) + 16) % 16;
            c = 1'b1;
            case (ph)
                0:  d = 8'h7C;
                5:  d = 8'hBC;
                9:  d = 8'h1C;
                12: d = 8'hFB;
                default: begin d = 8'((p * 7 + l * 31) & 255); c = 1'b0; end
            endcase
            if (kill_arm && l == 2 && ph == 0) begin
                d = 8'h00; c = 1'b0; kill_arm = 0;
            end
            lane_data_i[l*8 +: 8] = d;
            lane_ctrl_i[l] = c;
            lane_sync_i[l] = sync_v[l];
        end
        err_clr_i = clr_v;
        cyc_d++;
    endtask

    // Compare every output against the model, then drive the next inputs.
    task automatic tick();
        @(negedge clk);
        total++;
        if (out_data_o !== m_data || out_ctrl_o !== m_ctrl || deskew_ok_o !== m_ok ||
            align_err_o !== m_err || err_count_o !== CW'(m_cnt)) begin
            bad++;
            $display("FAIL R2/R4/R5/R6/R7/R8 model: got data=%h ctrl=%h ok=%b err=%b cnt=%0d exp data=%h ctrl=%h ok=%b err=%b cnt=%0d",
                     out_data_o, out_ctrl_o, deskew_ok_o, align_err_o, err_count_o,
                     m_data, m_ctrl, m_ok, m_err, m_cnt);
        end
        for (int l = 0; l < LANES; l++) begin
            if (out_ctrl_o[l] && out_data_o[l*8 +: 8] == 8'hFB) saw_fb++;
            if (out_ctrl_o[l] && (out_data_o[l*8 +: 8] == 8'h7C || out_data_o[l*8 +: 8] == 8'hBC ||
                                  out_data_o[l*8 +: 8] == 8'h1C)) saw_special++;
        end
        drive();
    endtask

    task automatic run(input int n);
        repeat (n) tick();
    endtask

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_skew(input int a, input int b, input int c, input int d);
        skew[0] = a; skew[1] = b; skew[2] = c; skew[3] = d;
    endtask

    initial begin
        int saved;
        bit found;
        rst_n = 0;
        for (int l = 0; l < LANES; l++) sync_v[l] = 1;
        set_skew(0, 1, 2, 4);
        drive();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1 ok", deskew_ok_o, 0);
        chk("R1 count", err_count_o, 0);
        chk("R1 data", out_data_o, 32'h07070707);
        chk("R1 ctrl", out_ctrl_o, 4'hF);

        run(60);
        chk("R4 aligned with spread 4", deskew_ok_o, 1);

        // R9: one lane loses a single align character
        kill_arm = 1;
        while (kill_arm) tick();
        run(8);
        chk("R9 mismatch clears ok", deskew_ok_o, 0);
        chk("R9 mismatch not counted", err_count_o, 0);
        run(30);
        chk("R9 realigned", deskew_ok_o, 1);

        set_skew(3, 3, 3, 3);
        run(60);
        chk("R4 aligned with zero spread", deskew_ok_o, 1);

        // R3: one cycle without lock
        sync_v[1] = 0; tick(); sync_v[1] = 1; tick();
        chk("R3 lock loss clears ok", deskew_ok_o, 0);
        sync_v[0] = 0;
        run(40);
        chk("R3 no search without lock", deskew_ok_o, 0);
        sync_v[0] = 1;
        run(40);
        chk("R3 search after lock", deskew_ok_o, 1);

        // R5: spread of exactly MAX_SKEW never aligns
        saved = err_count_o;
        set_skew(0, 5, 1, 2);
        run(200);
        chk("R5 not aligned", deskew_ok_o, 0);
        chk("R5 errors counted", err_count_o > saved, 1);
        run(200);
        chk("R6 saturates", err_count_o, 15);

        set_skew(0, 0, 0, 0);
        run(40);
        clr_v = 1; tick(); clr_v = 0; tick();
        chk("R6 clear", err_count_o, 0);
        run(40);
        chk("R6 stays cleared while aligned", err_count_o, 0);

        // R2: an all-lane 0xFB column passes with packing intact
        found = 0;
        for (int i = 0; i < 20 && !found; i++) begin
            tick();
            if (out_data_o == 32'hFBFBFBFB && out_ctrl_o == 4'hF) found = 1;
        end
        chk("R2 packed control column", found, 1);
        chk("R8 other control passes", saw_fb > 0, 1);
        chk("R8 no special on output", saw_special, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule